// File: doc/BRIEF.md
# Dual Status Register Interrupt Aggregator

This block gathers single-cycle event pulses from several neighbouring subsystems into two sticky status registers. The master register records port events, a summary of the bit-error tester, host-bus events and two local-bus events. The DMA register records queue traffic, queue access errors, FIFO overflow or underflow, and receive frame errors. Each register has its own per-bit mask. Every status bit records its event whether or not its mask bit is set.

Two active-low, level-sensitive, registered interrupt lines come out of the block. The host-bus line is low whenever any unmasked status bit is set. The local-bus line carries the same condition, but only while the local bus is in configuration mode. Two master bits have a meaning only in bridge mode, so the block hides them in configuration mode.

Software reaches the block through a four-word register port. Reads are combinational. A write to a status word clears each bit written as 1. A write to a mask word replaces the mask.

Top module: `status_irq_agg`

## Requirements
- R1: An event pulse at a rising edge sets its status bit, and the new value is readable from that edge on. A set bit stays set until software clears it. Master status bits: 0 is the tester summary, 1 is the host-bus event, 2 is the local-bus interrupt input, 3 is the local-bus ready timing error, and 4 upward are the port events in index order. The DMA status bit numbers equal their `dma_evt` indices: 0 receive free-queue read, 1 transmit pending-queue read, 2 receive done-queue write, 3 transmit done-queue write, 4 queue access error, 5 FIFO overflow or underflow, 6 CRC error, 7 abort, 8 octet-length error.
- R2: A write to a status word clears every bit whose write-data bit is 1. Bits written as 0 are left unchanged.
- R3: When an event arrives in the same cycle as a clear of its bit, the bit ends up set.
- R4: A write to a mask word replaces that mask. A mask bit of 1 enables the interrupt for its status bit. A status bit records its event even when its mask bit is 0.
- R5: `host_irq_n` is driven low one cycle after any status bit and its mask bit are both 1, in either register. Otherwise it is high.
- R6: `local_irq_n` follows the same condition as R5, also one cycle later, but only while `cfg_mode` is 1. While `cfg_mode` is 0 it stays high.
- R7: Master bit 0 is set only by a tester event whose matching `tst_en` bit is 1. A disabled tester event leaves the bit unchanged.
- R8: While `cfg_mode` is 0 (bridge mode), master bits 2 and 3 record their events. While `cfg_mode` is 1 (configuration mode), those two bits do not record events, read as 0, and do not contribute to either interrupt line.
- R9: Synchronous reset (`rst_n` low at a rising edge) clears all status and mask bits and drives both interrupt lines high.
- R10: The register addresses are 0 for master status, 1 for master mask, 2 for DMA status and 3 for DMA mask. Bits above a register's width read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 1 | 1 = local bus in configuration mode, 0 = bridge mode |
| port_evt | input | PORT_EVT_N | Port event pulses |
| tst_evt | input | 3 | Tester pulses: sync change, bit error, counter overflow |
| tst_en | input | 3 | Per-event enables applied inside the tester |
| host_bus_evt | input | 1 | Host-bus event pulse |
| lb_irq_evt | input | 1 | Interrupt seen on the local-bus interrupt input |
| lb_rdy_err_evt | input | 1 | Local-bus ready timing error pulse |
| dma_evt | input | 9 | DMA, FIFO and frame event pulses (bit order in R1) |
| reg_addr | input | 2 | Register select (R10) |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data of the selected register |
| host_irq_n | output | 1 | Host-bus interrupt, active low |
| local_irq_n | output | 1 | Local-bus interrupt, active low |

## Verification
The hardest situation to reach is a master local-bus bit that was recorded in bridge mode and is still held when the mode changes to configuration. It must then read as 0 and add nothing to the interrupts, yet it must reappear when the mode returns to bridge. The bench sets the bit in bridge mode, unmasks it and switches modes. It checks the read value and both interrupt lines on each side of the switch. The collision of an event with a write-1 clear is also driven directly, in one cycle, on the DMA register. A long random phase then mixes events, clears, mask writes and mode flips against a behavioural model.

// File: rtl/status_irq_pkg.sv
// Shared constants for the interrupt aggregator: register layout and address map.
// Assumes the master register width is derived from the port event count.
package status_irq_pkg;
    localparam int TST_EVT_N = 3;
    localparam int DMA_N     = 9;
    localparam int MS_TST    = 0;
    localparam int MS_HOST   = 1;
    localparam int MS_LBIRQ  = 2;
    localparam int MS_LBRDY  = 3;
    localparam int MS_PORT0  = 4;

    typedef enum logic [1:0] {
        A_MSTAT = 2'd0,
        A_MMASK = 2'd1,
        A_DSTAT = 2'd2,
        A_DMASK = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/stat_reg.sv
// Sticky status register with write-1-to-clear and a per-bit interrupt mask.
// The set vector arrives already gated. A set wins over a clear of the same bit.
// Bits in hide read as 0 and do not count toward the active output.
module stat_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic         clr_we,
    input  logic [W-1:0] clr_data,
    input  logic         mask_we,
    input  logic [W-1:0] mask_data,
    input  logic [W-1:0] hide,
    output logic [W-1:0] status_view,
    output logic [W-1:0] mask_q,
    output logic         active
);
    logic [W-1:0] status_q;
    logic [W-1:0] clr_eff;
    logic [W-1:0] keep;

    // Bits that this cycle's write clears.
    always_comb clr_eff = clr_we ? clr_data : '0;
    // Bits that survive the clear.
    always_comb keep = status_q & ~clr_eff;

    // Record events and apply clears; a set overrides a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= keep | set;
    end

    // Hold the mask until software rewrites it.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= mask_data;
    end

    // Visible status and the enabled-pending flag.
    always_comb begin
        status_view = status_q & ~hide;
        active      = |(status_view & mask_q);
    end

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set != '0) |=> ((status_q & $past(set)) == $past(set))); // R3
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((status_q & $past(clr_data & ~set)) == '0)); // R2
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & $past(keep)) == $past(keep))); // R1
endmodule

// File: rtl/irq_out.sv
// Registered active-low interrupt drivers. The local line is gated by the mode.
// Assumes the pending input is a combinational OR of the enabled status.
module irq_out (
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    input  logic cfg_mode,
    output logic host_irq_n,
    output logic local_irq_n
);
    // Register both lines one cycle after the pending condition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_irq_n  <= 1'b1;
            local_irq_n <= 1'b1;
        end else begin
            host_irq_n  <= ~pending;
            local_irq_n <= ~(pending & cfg_mode);
        end
    end
endmodule

// File: rtl/status_irq_agg.sv
// Top of the aggregator: builds the event vectors, decodes the register port,
// and drives the two interrupt lines. Assumes DATA_W is at least both register widths.
module status_irq_agg
    import status_irq_pkg::*;
#(
    parameter int PORT_EVT_N = 2,
    parameter int DATA_W     = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_mode,
    input  logic [PORT_EVT_N-1:0] port_evt,
    input  logic [TST_EVT_N-1:0]  tst_evt,
    input  logic [TST_EVT_N-1:0]  tst_en,
    input  logic                  host_bus_evt,
    input  logic                  lb_irq_evt,
    input  logic                  lb_rdy_err_evt,
    input  logic [DMA_N-1:0]      dma_evt,
    input  logic [1:0]            reg_addr,
    input  logic                  reg_wr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    output logic                  host_irq_n,
    output logic                  local_irq_n
);
    localparam int MS_W = MS_PORT0 + PORT_EVT_N;

    logic [MS_W-1:0]  m_set, m_hide, m_view, m_mask;
    logic [DMA_N-1:0] d_view, d_mask;
    logic             m_act, d_act, pending;
    logic             tst_hit;

    // Tester summary: any enabled tester event.
    always_comb tst_hit = |(tst_evt & tst_en);

    // Master event vector; bridge-only sources are blocked in configuration mode.
    always_comb begin
        m_set                          = '0;
        m_set[MS_TST]                  = tst_hit;
        m_set[MS_HOST]                 = host_bus_evt;
        m_set[MS_LBIRQ]                = lb_irq_evt & ~cfg_mode;
        m_set[MS_LBRDY]                = lb_rdy_err_evt & ~cfg_mode;
        m_set[MS_PORT0 +: PORT_EVT_N]  = port_evt;
        m_hide                         = '0;
        m_hide[MS_LBIRQ]               = cfg_mode;
        m_hide[MS_LBRDY]               = cfg_mode;
    end

    stat_reg #(.W(MS_W)) u_mreg (
        .clk        (clk),
        .rst_n      (rst_n),
        .set        (m_set),
        .clr_we     (reg_wr && reg_addr == A_MSTAT),
        .clr_data   (reg_wdata[MS_W-1:0]),
        .mask_we    (reg_wr && reg_addr == A_MMASK),
        .mask_data  (reg_wdata[MS_W-1:0]),
        .hide       (m_hide),
        .status_view(m_view),
        .mask_q     (m_mask),
        .active     (m_act)
    );

    stat_reg #(.W(DMA_N)) u_dreg (
        .clk        (clk),
        .rst_n      (rst_n),
        .set        (dma_evt),
        .clr_we     (reg_wr && reg_addr == A_DSTAT),
        .clr_data   (reg_wdata[DMA_N-1:0]),
        .mask_we    (reg_wr && reg_addr == A_DMASK),
        .mask_data  (reg_wdata[DMA_N-1:0]),
        .hide       ('0),
        .status_view(d_view),
        .mask_q     (d_mask),
        .active     (d_act)
    );

    // Either register has an enabled bit pending.
    always_comb pending = m_act | d_act;

    irq_out u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pending    (pending),
        .cfg_mode   (cfg_mode),
        .host_irq_n (host_irq_n),
        .local_irq_n(local_irq_n)
    );

    // Read multiplexer; unused upper bits read as zero.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_MSTAT: reg_rdata[MS_W-1:0]  = m_view;
            A_MMASK: reg_rdata[MS_W-1:0]  = m_mask;
            A_DSTAT: reg_rdata[DMA_N-1:0] = d_view;
            default: reg_rdata[DMA_N-1:0] = d_mask;
        endcase
    end

    AST_HOST_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n)
        (m_act || d_act) |=> !host_irq_n); // R5
    AST_HOST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(m_act || d_act) |=> host_irq_n); // R5
    AST_LOCAL_BRIDGE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_mode |=> local_irq_n); // R6
    AST_CFG_HIDES: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode && reg_addr == A_MSTAT) |-> (reg_rdata[MS_LBRDY:MS_LBIRQ] == 2'b00)); // R8
endmodule

// File: tb/status_irq_agg_tb.sv
module status_irq_agg_tb;
    localparam int CLK_PERIOD = 10;
    localparam int PN = 2;
    localparam int DW = 16;
    localparam int MSM = (1 << (4 + PN)) - 1;
    localparam int DMM = 511;

    logic clk = 0, rst_n = 0, cfg_mode = 0;
    logic [PN-1:0] port_evt = '0;
    logic [2:0] tst_evt = '0, tst_en = '0;
    logic host_bus_evt = 0, lb_irq_evt = 0, lb_rdy_err_evt = 0;
    logic [8:0] dma_evt = '0;
    logic [1:0] reg_addr = '0;
    logic reg_wr = 0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic host_irq_n, local_irq_n;

    int errors = 0, checks = 0;
    bit cmp_on = 0, done = 0;
    int ms = 0, mm = 0, ds = 0, dm = 0;
    bit eh = 1, el = 1;

    always #(CLK_PERIOD/2) clk = ~clk;

    status_irq_agg #(.PORT_EVT_N(PN), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .port_evt(port_evt),
        .tst_evt(tst_evt), .tst_en(tst_en), .host_bus_evt(host_bus_evt),
        .lb_irq_evt(lb_irq_evt), .lb_rdy_err_evt(lb_rdy_err_evt), .dma_evt(dma_evt),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .host_irq_n(host_irq_n), .local_irq_n(local_irq_n));

    function automatic int vis_ms();
        return cfg_mode ? (ms & ~12) : ms;
    endfunction

    function automatic int model_read();
        case (int'(reg_addr))
            0: return vis_ms();
            1: return mm;
            2: return ds;
            default: return dm;
        endcase
    endfunction

    // Behavioural reference, updated on each rising edge.
    always @(posedge clk) begin
        int setm, clrm;
        bit any;
        if (!rst_n) begin
            ms = 0; mm = 0; ds = 0; dm = 0; eh = 1; el = 1;
        end else begin
            any = ((vis_ms() & mm) != 0) || ((ds & dm) != 0);
            eh = !any;
            el = !(any && cfg_mode);
            setm = 0;
            if ((tst_evt & tst_en) != 0) setm += 1;
            if (host_bus_evt) setm += 2;
            if (lb_irq_evt && !cfg_mode) setm += 4;
            if (lb_rdy_err_evt && !cfg_mode) setm += 8;
            setm += int'(port_evt) << 4;
            clrm = (reg_wr && reg_addr == 2'd0) ? (int'(reg_wdata) & MSM) : 0;
            ms = (ms & ~clrm) | setm;
            if (reg_wr && reg_addr == 2'd1) mm = int'(reg_wdata) & MSM;
            clrm = (reg_wr && reg_addr == 2'd2) ? (int'(reg_wdata) & DMM) : 0;
            ds = (ds & ~clrm) | int'(dma_evt);
            if (reg_wr && reg_addr == 2'd3) dm = int'(reg_wdata) & DMM;
        end
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Compare outputs against the model away from the active edge.
    always @(negedge clk) if (cmp_on && !done) begin
        check("R5 host_irq_n", int'(host_irq_n), int'(eh));
        check("R6 local_irq_n", int'(local_irq_n), int'(el));
        check("R10 reg_rdata", int'(reg_rdata), model_read());
    end

    task automatic tick();
        @(negedge clk); #1;
    endtask

    task automatic idle();
        port_evt = '0; tst_evt = '0; host_bus_evt = 0; lb_irq_evt = 0;
        lb_rdy_err_evt = 0; dma_evt = '0; reg_wr = 0;
    endtask

    task automatic wr(int a, int d);
        idle(); reg_addr = 2'(a); reg_wr = 1; reg_wdata = DW'(d); tick(); idle();
    endtask

    task automatic rd(int a, output int v);
        idle(); reg_addr = 2'(a); #1; v = int'(reg_rdata); tick();
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1; errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
        end
    end

    initial begin
        int v;
        tick(); cmp_on = 1; tick(); tick();
        rst_n = 1;
        check("R9 host high", int'(host_irq_n), 1);
        check("R9 local high", int'(local_irq_n), 1);
        for (int a = 0; a < 4; a++) begin rd(a, v); check("R9 reg zero", v, 0); end
        // R1: DMA CRC bit and master host-bus bit
        idle(); dma_evt = 9'h040; host_bus_evt = 1; tick(); idle();
        rd(2, v); check("R1 dma crc set", v, 'h40);
        rd(0, v); check("R1 master host bit", v, 'h2);
        rd(2, v); check("R1 sticky", v, 'h40);
        // R4/R5: masked off, no irq; enable mask, one cycle latency
        check("R4 masked no irq", int'(host_irq_n), 1);
        wr(3, 'h40);
        check("R5 latency still high", int'(host_irq_n), 1);
        tick();
        check("R5 host low", int'(host_irq_n), 0);
        check("R6 bridge local high", int'(local_irq_n), 1);
        // R6: configuration mode routes to local
        cfg_mode = 1; tick(); tick();
        check("R6 cfg local low", int'(local_irq_n), 0);
        cfg_mode = 0; tick();
        // R2: clear
        idle(); dma_evt = 9'h001; tick();
        wr(2, 'h001); rd(2, v); check("R2 partial clear", v, 'h40);
        wr(2, 'h040); rd(2, v); check("R2 full clear", v, 0);
        tick(); check("R5 host released", int'(host_irq_n), 1);
        // R3: event with clear in the same cycle
        idle(); dma_evt = 9'h100; tick();
        idle(); reg_addr = 2'd2; reg_wr = 1; reg_wdata = 'h100; dma_evt = 9'h100; tick(); idle();
        rd(2, v); check("R3 event wins", v, 'h100);
        wr(2, 'h1FF);
        // R7: tester enables
        idle(); tst_en = 3'b010; tst_evt = 3'b001; tick(); idle();
        rd(0, v); check("R7 disabled ignored", v & 1, 0);
        idle(); tst_evt = 3'b010; tick(); idle();
        rd(0, v); check("R7 enabled sets", v & 1, 1);
        // R1 port events
        idle(); port_evt = 2'b10; tick(); idle();
        rd(0, v); check("R1 port bit5", v, 'h23);
        wr(0, 'h3F);
        // R8: bridge-only bits
        idle(); lb_irq_evt = 1; tick(); idle();
        rd(0, v); check("R8 bridge records", v, 'h4);
        wr(1, 'h4); tick();
        check("R8 bridge irq", int'(host_irq_n), 0);
        cfg_mode = 1;
        rd(0, v); check("R8 cfg reads zero", v, 0);
        tick();
        check("R8 cfg no host irq", int'(host_irq_n), 1);
        check("R8 cfg no local irq", int'(local_irq_n), 1);
        idle(); lb_rdy_err_evt = 1; tick(); idle();
        cfg_mode = 0;
        rd(0, v); check("R8 cfg event dropped", v, 'h4);
        wr(0, 'h3F); wr(1, 0);
        // Random mix
        for (int i = 0; i < 3000; i++) begin
            idle();
            if ($urandom_range(0, 7) == 0) dma_evt = 9'(1 << $urandom_range(0, 8));
            if ($urandom_range(0, 9) == 0) port_evt = PN'($urandom);
            if ($urandom_range(0, 9) == 0) host_bus_evt = 1;
            if ($urandom_range(0, 9) == 0) lb_irq_evt = 1;
            if ($urandom_range(0, 9) == 0) lb_rdy_err_evt = 1;
            tst_evt = ($urandom_range(0, 5) == 0) ? 3'($urandom) : 3'b0;
            if ($urandom_range(0, 31) == 0) tst_en = 3'($urandom);
            if ($urandom_range(0, 63) == 0) cfg_mode = ~cfg_mode;
            reg_addr = 2'($urandom);
            reg_wr = ($urandom_range(0, 5) == 0);
            reg_wdata = DW'($urandom);
            tick();
        end
        done = 1;
        summary();
    end
endmodule